// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous Memory

This block is a small single-port synchronous memory for a bus that is used every cycle. A rising clock edge registers the address, the command and the three chip selects. The read result then flows straight out of the array during the following cycle. A write takes its address on one edge and its data and lane strobes on the next. Because of this, a read may directly follow a write, and a write may directly follow a read, with no idle slot between them.

Each access either loads a fresh address or continues the access already in progress. A continued access steps through a four-word group. The order is either linear or interleaved, chosen by a static mode input. A clock-enable input that is held high stalls the whole block. An output-enable input gates the read result.

Top module: `fts_sram`

## Requirements
- R1: After reset the block is deselected: `dout_valid_o` is 0 and `dout_o` is all zeros until a read is loaded.
- R2: A load cycle (`cont_i`=0) selects the block only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. Any other combination deselects it. The following cycle shows no valid output, and a write command given with a bad select changes no word.
- R3: A selected load with `wr_n_i`=1 starts a read. In the cycle after that edge, `dout_valid_o`=1 and `dout_o` holds the addressed word.
- R4: A selected load with `wr_n_i`=0 starts a write. The data and the active-low lane strobes `lane_n_i` are taken on the next edge. Lane k is bits [9k+8:9k] of the word, and only lanes whose strobe is 0 are updated.
- R5: A write data cycle with all four strobes at 1, or with `din_valid_i`=0, leaves the word unchanged.
- R6: A read loaded on the edge that completes a write to the same address returns the newly written data. Reads and writes may alternate on consecutive edges.
- R7: With `linear_i`=1, each continue cycle after a load at address A accesses word offset (A[1:0]+n) mod 4 within the same four-word group, where n counts the continue cycles.
- R8: With `linear_i`=0, the nth continue cycle accesses offset A[1:0] XOR n.
- R9: A continue cycle while deselected keeps the block deselected, whatever the select inputs show.
- R10: While `clk_en_n_i`=1, edges are ignored. No word is written, the command state holds, and the output holds for an unchanged `oe_n_i`.
- R11: With `oe_n_i`=1, a read is a dummy read: `dout_valid_o`=0 and `dout_o` is zero. Output data is zero whenever it is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n_i | input | 1 | Active-low clock enable; high stalls the block |
| addr_i | input | ADDR_W | Word address for load cycles |
| cont_i | input | 1 | 1 = continue current access, 0 = load new access |
| wr_n_i | input | 1 | Load command: 1 = read, 0 = write |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| linear_i | input | 1 | Static burst order: 1 = linear, 0 = interleaved |
| lane_n_i | input | LANES | Active-low lane write strobes (data cycle) |
| din_i | input | LANES*LANE_W | Write data (data cycle) |
| din_valid_i | input | 1 | Write data qualifier |
| dout_o | output | LANES*LANE_W | Read data, zero when not valid |
| dout_valid_o | output | 1 | Read data valid |

## Verification
Read data is due in the cycle right after the edge that registers the read. There is one register on that path, and the array read and output gating are combinational after it. A write lands on the edge after its address edge, so the earliest read that sees it is loaded on that same edge and observed one cycle later. The driver applies each command at a falling edge and pushes the expected output for the following cycle. The monitor pops that entry 2 ns after the next rising edge, so every comparison falls in the cycle the result is due.

// File: rtl/fts_pkg.sv
package fts_pkg;
    // Command held between edges
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Burst group is four words: two offset bits
    localparam int OFF_W = 2;
endpackage

// File: rtl/fts_burst.sv
// Word offset inside the four-word group (R7 linear, R8 interleaved)
module fts_burst #(
    parameter int OFF_W = 2
) (
    input  logic             linear_i,
    input  logic [OFF_W-1:0] start_i,
    input  logic [OFF_W-1:0] step_i,
    output logic [OFF_W-1:0] off_o
);
    always_comb begin
        if (linear_i) off_o = start_i + step_i;
        else          off_o = start_i ^ step_i;
    end
endmodule

// File: rtl/fts_array.sv
// Storage split into independently written lanes (R4)
module fts_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    cont_i,
    input  logic                    wr_n_i,
    input  logic                    sel_a_n_i,
    input  logic                    sel_b_i,
    input  logic                    sel_c_n_i,
    input  logic                    oe_n_i,
    input  logic                    linear_i,
    input  logic [LANES-1:0]        lane_n_i,
    input  logic [LANES*LANE_W-1:0] din_i,
    input  logic                    din_valid_i,
    output logic [LANES*LANE_W-1:0] dout_o,
    output logic                    dout_valid_o
);
    import fts_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e              op;
        logic [ADDR_W-1:0] base;
        logic [OFF_W-1:0]  step;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              selected;
    logic              commit;
    logic [LANES-1:0]  lane_we;
    logic [OFF_W-1:0]  off;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] rdata;

    fts_burst #(.OFF_W(OFF_W)) u_burst (
        .linear_i (linear_i),
        .start_i  (st_q.base[OFF_W-1:0]),
        .step_i   (st_q.step),
        .off_o    (off)
    );

    fts_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .addr    (eff_addr),
        .wdata   (din_i),
        .rdata   (rdata)
    );

    always_comb begin
        // R2: all three selects must agree
        selected = !sel_a_n_i && sel_b_i && !sel_c_n_i;
        eff_addr = {st_q.base[ADDR_W-1:OFF_W], off};

        // R4/R5: the data cycle of a write commits only enabled lanes
        commit  = !clk_en_n_i && (st_q.op == OP_WR) && din_valid_i;
        lane_we = commit ? ~lane_n_i : '0;

        st_d = st_q;
        if (!clk_en_n_i) begin            // R10: stall holds everything
            if (!cont_i) begin
                if (selected) begin
                    st_d.op   = wr_n_i ? OP_RD : OP_WR;
                    st_d.base = addr_i;
                    st_d.step = '0;
                end else begin
                    st_d.op = OP_IDLE;
                end
            end else if (st_q.op != OP_IDLE) begin
                st_d.step = st_q.step + OFF_W'(1);   // R7/R8
            end                                       // R9: idle stays idle
        end

        // R3/R11: flow-through read, gated by output enable
        dout_valid_o = (st_q.op == OP_RD) && !oe_n_i;
        dout_o       = dout_valid_o ? rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_IDLE, base: '0, step: '0};   // R1
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n_i,
    input logic              cont_i,
    input logic              wr_n_i,
    input logic              sel_a_n_i,
    input logic              sel_b_i,
    input logic              sel_c_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_valid_o,
    input logic [1:0]        cur_op
);
    logic sel_ok;
    assign sel_ok = !sel_a_n_i && sel_b_i && !sel_c_n_i;

    assert_bad_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n_i && !cont_i && !sel_ok) |=> !dout_valid_o);

    assert_read_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n_i && !cont_i && sel_ok && wr_n_i) |=> (oe_n_i || dout_valid_o));

    assert_idle_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n_i && cont_i && cur_op == 2'd0) |=> (cur_op == 2'd0));

    assert_stall_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n_i |=> $stable(cur_op));

    assert_stall_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n_i |=> (!$stable(oe_n_i) || ($stable(dout_valid_o) && $stable(dout_o))));

    assert_dummy_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!dout_valid_o && dout_o == '0));
endmodule

bind fts_sram fts_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en_n_i   (clk_en_n_i),
    .cont_i       (cont_i),
    .wr_n_i       (wr_n_i),
    .sel_a_n_i    (sel_a_n_i),
    .sel_b_i      (sel_b_i),
    .sel_c_n_i    (sel_c_n_i),
    .oe_n_i       (oe_n_i),
    .dout_o       (dout_o),
    .dout_valid_o (dout_valid_o),
    .cur_op       (st_q.op)
);

// File: tb/fts_sram_tb.sv
module fts_sram_tb;
    localparam logic [2:0] SEL_OK = 3'b010;   // {a_n, b, c_n}

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic        cont_i = 1'b0;
    logic        wr_n_i = 1'b1;
    logic        sel_a_n_i = 1'b1;
    logic        sel_b_i = 1'b0;
    logic        sel_c_n_i = 1'b1;
    logic        oe_n_i = 1'b1;
    logic        linear_i = 1'b1;
    logic [3:0]  lane_n_i = 4'hF;
    logic [35:0] din_i = '0;
    logic        din_valid_i = 1'b0;
    logic [35:0] dout_o;
    logic        dout_valid_o;

    always #4 clk = ~clk;

    fts_sram u_dut (.*);

    typedef struct {
        bit          vld;
        logic [35:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference model
    logic [35:0] m_mem [64];
    int          m_op = 0;       // 0 idle, 1 read, 2 write
    logic [5:0]  m_base = '0;
    logic [1:0]  m_step = '0;
    bit          m_lin = 1'b1;

    function automatic logic [5:0] model_eff();
        logic [1:0] o;
        o = m_lin ? m_base[1:0] + m_step : m_base[1:0] ^ m_step;
        return {m_base[5:2], o};
    endfunction

    function automatic logic [35:0] patt(input logic [5:0] a);
        return {a, a, a, a, a, a};
    endfunction

    task automatic cmd(input logic [2:0] sel, input bit cont, input bit wr_n,
                       input logic [5:0] a, input bit oe_n, input bit cke_n,
                       input logic [3:0] ln, input logic [35:0] d, input bit dv,
                       input string tag);
        exp_t e;
        logic [5:0] ea;
        @(negedge clk);
        {sel_a_n_i, sel_b_i, sel_c_n_i} = sel;
        cont_i = cont; wr_n_i = wr_n; addr_i = a; oe_n_i = oe_n;
        clk_en_n_i = cke_n; lane_n_i = ln; din_i = d; din_valid_i = dv;
        linear_i = m_lin;
        if (!cke_n) begin
            if (m_op == 2 && dv) begin
                ea = model_eff();
                for (int k = 0; k < 4; k++)
                    if (!ln[k]) m_mem[ea][k*9 +: 9] = d[k*9 +: 9];
            end
            if (!cont) begin
                if (sel == SEL_OK) begin
                    m_op = wr_n ? 1 : 2; m_base = a; m_step = '0;
                end else m_op = 0;
            end else if (m_op != 0) m_step = m_step + 2'd1;
        end
        e.vld  = (m_op == 1) && !oe_n;
        e.data = e.vld ? m_mem[model_eff()] : '0;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        cmd(SEL_OK, 0, 1, a, 0, 0, 4'hF, '0, 0, tag);
    endtask

    task automatic nop(input string tag);
        cmd(3'b110, 0, 1, '0, 0, 0, 4'hF, '0, 0, tag);
    endtask

    // Monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (dout_valid_o !== e.vld || dout_o !== e.data) begin
                failures++;
                $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
                         e.tag, dout_valid_o, dout_o, e.vld, e.data);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: valid=%b data=%h expected valid=x data=x", dout_valid_o, dout_o);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R1 reset state
        if (dout_valid_o !== 1'b0 || dout_o !== '0) begin
            failures++;
            $display("FAIL R1: valid=%b data=%h expected valid=0 data=0", dout_valid_o, dout_o);
        end
        @(negedge clk) rst_n = 1'b1;
        nop("R1");

        // R4/R7: fill every word with linear write bursts
        for (int k = 0; k < 16; k++)
            for (int j = 0; j < 4; j++)
                cmd(SEL_OK, j != 0, 0, 6'(k*4), 1, 0, 4'h0, patt(model_eff()), m_op == 2, "R4");
        cmd(3'b110, 0, 1, '0, 1, 0, 4'h0, patt(model_eff()), 1, "R4");

        rd(6'd5, "R3");
        rd(6'd6, "R7");                                  // 6,7,4,5
        for (int j = 0; j < 3; j++) cmd(SEL_OK, 1, 1, '0, 0, 0, 4'hF, '0, 0, "R7");

        // R6: alternate write and read on the same words
        cmd(SEL_OK, 0, 0, 6'd33, 0, 0, 4'hF, '0, 0, "R6");
        cmd(SEL_OK, 0, 1, 6'd33, 0, 0, 4'h0, 36'h5A5A5A5A5, 1, "R6");
        cmd(SEL_OK, 0, 0, 6'd34, 0, 0, 4'hF, '0, 0, "R6");
        cmd(SEL_OK, 0, 1, 6'd34, 0, 0, 4'h0, 36'hA5A5A5A5A, 1, "R6");
        rd(6'd33, "R6");

        // R4: lanes 0 and 2 only
        cmd(SEL_OK, 0, 0, 6'd20, 0, 0, 4'hF, '0, 0, "R4");
        cmd(SEL_OK, 0, 1, 6'd20, 0, 0, 4'b1010, 36'hFFFFFFFFF, 1, "R4");

        // R5: abort by strobes and by missing data qualifier
        cmd(SEL_OK, 0, 0, 6'd21, 0, 0, 4'hF, '0, 0, "R5");
        cmd(SEL_OK, 0, 1, 6'd21, 0, 0, 4'hF, '0, 1, "R5");
        cmd(SEL_OK, 0, 0, 6'd22, 0, 0, 4'hF, '0, 0, "R5");
        cmd(SEL_OK, 0, 1, 6'd22, 0, 0, 4'h0, '0, 0, "R5");

        // R2: each select wrong, plus a write that must not land
        cmd(3'b110, 0, 1, 6'd5, 0, 0, 4'hF, '0, 0, "R2");
        cmd(3'b000, 0, 1, 6'd5, 0, 0, 4'hF, '0, 0, "R2");
        cmd(3'b011, 0, 1, 6'd5, 0, 0, 4'hF, '0, 0, "R2");
        cmd(3'b000, 0, 0, 6'd23, 0, 0, 4'hF, '0, 0, "R2");
        cmd(SEL_OK, 0, 1, 6'd23, 0, 0, 4'h0, '0, 1, "R2");

        // R9: continue after deselect
        nop("R9");
        cmd(SEL_OK, 1, 1, 6'd7, 0, 0, 4'hF, '0, 0, "R9");
        cmd(SEL_OK, 1, 0, 6'd7, 0, 0, 4'hF, '0, 0, "R9");

        // R10: stall during a read burst and during a write data cycle
        rd(6'd40, "R10");
        cmd(SEL_OK, 0, 1, 6'd3, 0, 1, 4'hF, '0, 0, "R10");
        cmd(3'b110, 0, 0, 6'd9, 0, 1, 4'hF, '0, 0, "R10");
        cmd(SEL_OK, 1, 1, '0, 0, 0, 4'hF, '0, 0, "R10");
        cmd(SEL_OK, 0, 0, 6'd41, 0, 0, 4'hF, '0, 0, "R10");
        cmd(SEL_OK, 0, 1, 6'd2, 0, 1, 4'h0, 36'h123456789, 1, "R10");
        cmd(SEL_OK, 0, 1, 6'd41, 0, 0, 4'h0, 36'h0FEDCBA98, 1, "R10");

        // R11: dummy reads
        cmd(SEL_OK, 0, 1, 6'd5, 1, 0, 4'hF, '0, 0, "R11");
        cmd(SEL_OK, 1, 1, '0, 0, 0, 4'hF, '0, 0, "R11");
        cmd(SEL_OK, 1, 1, '0, 1, 0, 4'hF, '0, 0, "R11");

        // R8: interleaved order
        nop("R8");
        m_lin = 1'b0;
        rd(6'd9, "R8");                                  // 9,8,11,10
        for (int j = 0; j < 3; j++) cmd(SEL_OK, 1, 1, '0, 0, 0, 4'hF, '0, 0, "R8");
        rd(6'd14, "R8");                                 // 14,15,12,13
        for (int j = 0; j < 3; j++) cmd(SEL_OK, 1, 1, '0, 0, 0, 4'hF, '0, 0, "R8");

        nop("R1");
        repeat (3) @(posedge clk);
        #3;
        summary();
    end
endmodule